// File: doc/BRIEF.md
# Opcode-Selected Integer ALU

This block is a purely combinational integer arithmetic logic unit. Two two's-complement operands of a configurable width enter together with a 3-bit operation code and a carry input. In the same cycle the block returns a result word and four condition flags for a status register: a carry out, a signed overflow, a zero flag and a negative flag. A control unit places the operands and the code on the inputs and captures the outputs on its next clock edge.

Every result bit is picked by its own multiplexer. The inputs to that multiplexer come from parallel bitwise XOR, AND and OR paths, from a ripple-carry full-adder chain, and from the unary paths. A small decoder turns the operation code into a bundle of steering strobes. The strobes choose the result source. They also control the inversion of operand B and the adder's carry seed, so subtraction runs through the same adder as an add of the inverted B with a carry seed of one. Bit 0 of every operand and of the result is the least significant bit. The default operand width is 2 bits.

Top module: `opsel_alu`

## Requirements
- R1: Code 3'b000 gives result = opA XOR opB.
- R2: Code 3'b001 gives result = opA AND opB.
- R3: Code 3'b010 gives result = opA OR opB.
- R4: Code 3'b011 gives {carryOut, result} = opA + opB + carryIn as an unsigned sum of WIDTH+1 bits, where bit 0 is the least significant bit. In this mode overflow is 1 exactly when opA and opB have the same sign bit and the sign bit of result differs from it.
- R5: Code 3'b100 gives result = opA - opB modulo 2^WIDTH, computed as opA + ~opB + 1. carryIn has no effect in this mode. carryOut is 1 exactly when opA >= opB as unsigned numbers. overflow is 1 exactly when the sign bits of opA and opB differ and the sign bit of result differs from that of opA.
- R6: Code 3'b101 gives result = NOT opA. Code 3'b110 gives result = NOT opB. Code 3'b111 gives result = opA.
- R7: For every code other than 3'b011 and 3'b100, carryOut and overflow are 0, and carryIn has no effect on any output.
- R8: zero is 1 exactly when every bit of result is 0.
- R9: negative equals the most significant bit of result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand, two's complement |
| opB | input | WIDTH | Second operand, two's complement |
| opCode | input | 3 | Operation code selecting the result source |
| carryIn | input | 1 | Carry input, used by the add code only |
| result | output | WIDTH | Result word |
| carryOut | output | 1 | Carry out of the most significant adder bit for add and subtract, otherwise 0 |
| overflow | output | 1 | Signed overflow for add and subtract, otherwise 0 |
| zero | output | 1 | Set when result is all zeros |
| negative | output | 1 | Copy of the result sign bit |

## Verification
The full cross product of both operands, carry input and all eight codes is applied at the 2-bit width. This separates a swapped multiplexer leg, an undecoded top opcode bit, and a carry seed that leaks into the wrong code. Directed cases come before the sweep. Equal operands under XOR and subtract tell a working zero flag from a stuck one. The most-positive and most-negative operand pairs tell signed overflow apart from unsigned carry. Pairs with A below B and with A equal to B tell the no-borrow carry polarity of subtract from an inverted one. Each logic and unary code is applied with both carry-input values, which shows that the carry input cannot leak into those results.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  typedef enum logic [2:0] {
    OP_XOR  = 3'b000,
    OP_AND  = 3'b001,
    OP_OR   = 3'b010,
    OP_ADD  = 3'b011,
    OP_SUB  = 3'b100,
    OP_NOTA = 3'b101,
    OP_NOTB = 3'b110,
    OP_PASA = 3'b111
  } opCode_e;

  typedef enum logic [2:0] {
    SEL_XOR,
    SEL_AND,
    SEL_OR,
    SEL_SUM,
    SEL_NOTA,
    SEL_NOTB,
    SEL_PASA
  } resSel_e;

  typedef struct packed {
    resSel_e resSel;
    logic    invertB;
    logic    seedOne;
    logic    useCarryIn;
    logic    arithOp;
  } aluCtl_t;

endpackage

// File: rtl/opsel_alu_ctrl.sv
module opsel_alu_ctrl
  import opsel_alu_pkg::*;
(
  input  logic [2:0] opCode,
  output aluCtl_t    ctl
);

  always_comb begin
    ctl = '{resSel: SEL_XOR, invertB: 1'b0, seedOne: 1'b0,
            useCarryIn: 1'b0, arithOp: 1'b0};
    unique case (opCode)
      OP_XOR:  ctl.resSel = SEL_XOR;
      OP_AND:  ctl.resSel = SEL_AND;
      OP_OR:   ctl.resSel = SEL_OR;
      OP_ADD: begin
        ctl.resSel     = SEL_SUM;
        ctl.useCarryIn = 1'b1;
        ctl.arithOp    = 1'b1;
      end
      OP_SUB: begin
        ctl.resSel  = SEL_SUM;
        ctl.invertB = 1'b1;
        ctl.seedOne = 1'b1;
        ctl.arithOp = 1'b1;
      end
      OP_NOTA: ctl.resSel = SEL_NOTA;
      OP_NOTB: ctl.resSel = SEL_NOTB;
      OP_PASA: ctl.resSel = SEL_PASA;
      default: ctl.resSel = SEL_XOR;
    endcase
  end

  // R5: subtract must seed one and never take the external carry
  always_comb begin
    if (opCode == 3'b100)
      assert_sub_seed_R5: assert (ctl.seedOne && !ctl.useCarryIn && ctl.invertB)
        else $error("subtract strobes wrong");
  end

endmodule

// File: rtl/opsel_alu_datapath.sv
module opsel_alu_datapath
  import opsel_alu_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  aluCtl_t          ctl,
  output logic [WIDTH-1:0] resWord,
  output logic             carryTop,
  output logic             carryBelowTop
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sumBits;

  assign carryChain[0] = ctl.seedOne | (ctl.useCarryIn & carryIn);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic halfSum;
    assign bEff[i]          = opB[i] ^ ctl.invertB;
    assign halfSum          = opA[i] ^ bEff[i];
    assign sumBits[i]       = halfSum ^ carryChain[i];
    assign carryChain[i+1]  = (opA[i] & bEff[i]) | (halfSum & carryChain[i]);

    always_comb begin
      unique case (ctl.resSel)
        SEL_XOR:  resWord[i] = opA[i] ^ opB[i];
        SEL_AND:  resWord[i] = opA[i] & opB[i];
        SEL_OR:   resWord[i] = opA[i] | opB[i];
        SEL_SUM:  resWord[i] = sumBits[i];
        SEL_NOTA: resWord[i] = ~opA[i];
        SEL_NOTB: resWord[i] = ~opB[i];
        SEL_PASA: resWord[i] = opA[i];
        default:  resWord[i] = 1'b0;
      endcase
    end
  end

  assign carryTop      = carryChain[WIDTH];
  assign carryBelowTop = carryChain[LAST];

endmodule

// File: rtl/opsel_alu_flags.sv
module opsel_alu_flags #(
  parameter int WIDTH = 2
) (
  input  logic [WIDTH-1:0] resWord,
  input  logic             carryTop,
  input  logic             carryBelowTop,
  input  logic             arithOp,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero,
  output logic             negative
);

  assign carryOut = arithOp & carryTop;
  assign overflow = arithOp & (carryTop ^ carryBelowTop);
  assign zero     = ~|resWord;
  assign negative = resWord[WIDTH-1];

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opCode,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero,
  output logic             negative
);

  aluCtl_t          ctl;
  logic [WIDTH-1:0] resWord;
  logic             carryTop;
  logic             carryBelowTop;

  opsel_alu_ctrl u_ctrl (
    .opCode (opCode),
    .ctl    (ctl)
  );

  opsel_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA           (opA),
    .opB           (opB),
    .carryIn       (carryIn),
    .ctl           (ctl),
    .resWord       (resWord),
    .carryTop      (carryTop),
    .carryBelowTop (carryBelowTop)
  );

  opsel_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .resWord       (resWord),
    .carryTop      (carryTop),
    .carryBelowTop (carryBelowTop),
    .arithOp       (ctl.arithOp),
    .carryOut      (carryOut),
    .overflow      (overflow),
    .zero          (zero),
    .negative      (negative)
  );

  assign result = resWord;

  always_comb begin
    if (opCode == 3'b000)
      assert_xor_R1: assert (result == (opA ^ opB)) else $error("xor mismatch");
    if (opCode == 3'b011)
      assert_add_sum_R4: assert ({carryOut, result} ==
                                 ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
        else $error("add mismatch");
    if (opCode == 3'b100)
      assert_sub_diff_R5: assert (result == WIDTH'(opA - opB)) else $error("sub mismatch");
    if (opCode != 3'b011 && opCode != 3'b100)
      assert_no_flags_logic_R7: assert (!carryOut && !overflow) else $error("flag on logic op");
    if (opCode == 3'b000 && opA == opB)
      assert_zero_equal_R8: assert (zero) else $error("zero flag missing");
    if (opCode == 3'b101)
      assert_neg_nota_R9: assert (negative == ~opA[WIDTH-1]) else $error("negative wrong");
  end

endmodule

// File: tb/tb_opsel_alu.sv
`timescale 1ns/1ps
module tb_opsel_alu;

  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   opCode = 3'b000;
  logic         carryIn = 1'b0;
  logic [W-1:0] result;
  logic         carryOut, overflow, zero, negative;

  int vecCount  = 0;
  int missCount = 0;
  bit finished  = 1'b0;

  always #2.5 clk = ~clk;

  opsel_alu #(.WIDTH(W)) dut (
    .opA(opA), .opB(opB), .opCode(opCode), .carryIn(carryIn),
    .result(result), .carryOut(carryOut), .overflow(overflow),
    .zero(zero), .negative(negative)
  );

  // Reference derived from the requirement list
  function automatic logic [W+3:0] refModel(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic [2:0] op, input logic ci);
    logic [W:0]   wide;
    logic [W-1:0] r;
    logic         co, ov;
    co = 1'b0; ov = 1'b0; r = '0;
    case (op)
      3'b000: r = a ^ b;
      3'b001: r = a & b;
      3'b010: r = a | b;
      3'b011: begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        r = wide[W-1:0]; co = wide[W];
        ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'b100: begin
        r  = W'(a - b);
        co = (a >= b);
        ov = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'b101: r = ~a;
      3'b110: r = ~b;
      default: r = a;
    endcase
    return {r, co, ov, (r == '0), r[W-1]};
  endfunction

  task automatic applyVec(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [2:0] op, input logic ci, input string tag);
    logic [W+3:0] expv, actv;
    @(posedge clk);
    opA = a; opB = b; opCode = op; carryIn = ci;
    @(negedge clk);
    expv = refModel(a, b, op, ci);
    actv = {result, carryOut, overflow, zero, negative};
    vecCount++;
    if (actv !== expv) begin
      missCount++;
      $display("FAIL %s op=%b a=%0d b=%0d ci=%0d actual={res,co,ov,z,n}=%b expected=%b",
               tag, op, a, b, ci, actv, expv);
    end
  endtask

  task automatic checkReset();
    @(negedge clk);
    vecCount++;
    if ({result, carryOut, overflow, zero, negative} !== {{W{1'b0}}, 4'b0010}) begin
      missCount++;
      $display("FAIL R8 reset state actual=%b expected=%b",
               {result, carryOut, overflow, zero, negative}, {{W{1'b0}}, 4'b0010});
    end
  endtask

  task automatic testLogic();
    for (int ci = 0; ci < 2; ci++) begin
      applyVec(2'b01, 2'b11, 3'b000, ci[0], "R1");
      applyVec(2'b10, 2'b11, 3'b001, ci[0], "R2");
      applyVec(2'b01, 2'b10, 3'b010, ci[0], "R3");
      applyVec(2'b00, 2'b00, 3'b010, ci[0], "R7");
    end
  endtask

  task automatic testAdd();
    applyVec(2'b01, 2'b01, 3'b011, 1'b0, "R4");
    applyVec(2'b11, 2'b01, 3'b011, 1'b0, "R4");
    applyVec(2'b10, 2'b10, 3'b011, 1'b0, "R4");
    applyVec(2'b01, 2'b00, 3'b011, 1'b1, "R4");
    applyVec(2'b11, 2'b11, 3'b011, 1'b1, "R4");
  endtask

  task automatic testSub();
    for (int ci = 0; ci < 2; ci++) begin
      applyVec(2'b10, 2'b10, 3'b100, ci[0], "R5");
      applyVec(2'b00, 2'b01, 3'b100, ci[0], "R5");
      applyVec(2'b10, 2'b01, 3'b100, ci[0], "R5");
      applyVec(2'b01, 2'b10, 3'b100, ci[0], "R5");
    end
  endtask

  task automatic testUnary();
    for (int ci = 0; ci < 2; ci++) begin
      applyVec(2'b10, 2'b00, 3'b101, ci[0], "R6");
      applyVec(2'b00, 2'b01, 3'b110, ci[0], "R6");
      applyVec(2'b11, 2'b00, 3'b111, ci[0], "R6");
      applyVec(2'b11, 2'b00, 3'b101, ci[0], "R9");
    end
  endtask

  task automatic testFlags();
    applyVec(2'b11, 2'b11, 3'b000, 1'b1, "R8");
    applyVec(2'b10, 2'b01, 3'b010, 1'b0, "R9");
    applyVec(2'b01, 2'b11, 3'b011, 1'b0, "R8");
  endtask

  task automatic testSweep();
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          for (int ci = 0; ci < 2; ci++)
            applyVec(W'(a), W'(b), op[2:0], ci[0], "R7 sweep");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    checkReset();
    testLogic();
    testAdd();
    testSub();
    testUnary();
    testFlags();
    testSweep();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule